// File: doc/BRIEF.md
# Logarithmic-Depth Prefix Adder

This block adds two unsigned binary operands of equal width plus a single incoming carry, and returns the truncated sum together with the outgoing carry. It is purely combinational. The carries do not ripple from bit to bit. Instead, each bit position first forms its own generate and propagate pair. Those pairs then pass through a sparse prefix tree. An upward sweep merges ever larger aligned groups. A downward sweep then fills in the prefixes that the upward sweep did not produce. The logic depth therefore grows with the logarithm of the width, and the operator count stays close to twice the width.

The incoming carry is handled as the generate signal of an imaginary position just below bit 0. It is merged into bit 0 before the tree, so every prefix the tree produces already includes it. The carry into each bit is the prefix generate of all positions below that bit. Each sum bit is that bit's propagate XORed with its carry. The operand width is a parameter and must be a power of two, at least 2. It is typically instantiated at 8 or 32 bits inside a datapath.

Top module: `bk_adder`

## Requirements
- R1: For every input, `sum` equals the low WIDTH bits of a + b + cin taken as unsigned integers.
- R2: `cout` equals bit WIDTH of a + b + cin. So when `cout` is 1, `sum` is no larger than either operand, and when `cout` is 0, `sum` is no smaller than either operand.
- R3: With cin = 0, `{cout, sum}` equals the plain unsigned sum a + b.
- R4: When every bit position propagates (a XOR b all ones), `sum` is all ones and `cout` is 0 for cin = 0. For cin = 1, `sum` is all zeros and `cout` is 1.
- R5: With both operands zero, `sum` equals cin in bit 0 and zeros elsewhere, and `cout` is 0.
- R6: Swapping a and b leaves `sum` and `cout` unchanged.
- R7: With both operands all ones and cin = 1, `sum` is all ones and `cout` is 1.
- R8: The same description is correct at WIDTH = 8, checked over every operand pair and both carry-in values, and at WIDTH = 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Incoming carry, weight 1 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bound checker tests the arithmetic total, the magnitude relation implied by the carry out, the all-propagate result, the zero-operand result and the saturated all-ones result whenever the inputs change. Symmetry under operand swap cannot be seen in one input combination, so only the bench shows it, by comparing paired applications. The same holds for complete coverage at 8 bits. At 32 bits, random vectors from a fixed seed plus directed carry-chain patterns show that the sparse downward sweep fills in every carry position.

// File: rtl/bk_pkg.sv
package bk_pkg;

    // generate / propagate pair describing one bit or one block of bits
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // direction of one row of the prefix tree
    typedef enum logic {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_e;

    // combine an upper block with the block directly beneath it
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/bk_gp_gen.sv
module bk_gp_gen
    import bk_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] prop,
    output gp_t  [WIDTH-1:0] leaf
);
    gp_t carry_node;

    // the incoming carry acts as a generating position below bit 0
    assign carry_node = '{g: cin, p: 1'b0};

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        gp_t raw;
        assign raw.g   = a[i] & b[i];
        assign raw.p   = a[i] ^ b[i];
        assign prop[i] = raw.p;
        if (i == 0) begin : g_fold
            assign leaf[i] = gp_merge(raw, carry_node);
        end else begin : g_plain
            assign leaf[i] = raw;
        end
    end
endmodule

// File: rtl/bk_prefix_row.sv
module bk_prefix_row
    import bk_pkg::*;
#(
    parameter int     WIDTH = 32,
    parameter int     LVL   = 0,
    parameter sweep_e MODE  = SWEEP_UP
) (
    input  gp_t [WIDTH-1:0] din,
    output gp_t [WIDTH-1:0] dout
);
    localparam int STEP = 1 << LVL;
    localparam int SPAN = 2 * STEP;

    always_comb begin
        dout = din;
        for (int j = 0; j < WIDTH; j++) begin
            if (MODE == SWEEP_UP) begin
                // top of each aligned group absorbs its lower half
                if (((j + 1) % SPAN) == 0) begin
                    dout[j] = gp_merge(din[j], din[j - STEP]);
                end
            end else begin
                // middle of a group picks up the finished prefix below it
                if ((((j + 1) % SPAN) == STEP) && (j > STEP)) begin
                    dout[j] = gp_merge(din[j], din[j - STEP]);
                end
            end
        end
    end
endmodule

// File: rtl/bk_prefix_net.sv
module bk_prefix_net
    import bk_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  gp_t [WIDTH-1:0] leaf,
    output gp_t [WIDTH-1:0] prefix
);
    localparam int LEVELS = $clog2(WIDTH);
    localparam int NSTAGE = 2 * LEVELS - 1;

    gp_t [WIDTH-1:0] link [0:NSTAGE];

    assign link[0] = leaf;

    for (genvar u = 0; u < LEVELS; u++) begin : g_up
        bk_prefix_row #(
            .WIDTH (WIDTH),
            .LVL   (u),
            .MODE  (SWEEP_UP)
        ) row_i (
            .din  (link[u]),
            .dout (link[u + 1])
        );
    end

    for (genvar d = 0; d < LEVELS - 1; d++) begin : g_down
        bk_prefix_row #(
            .WIDTH (WIDTH),
            .LVL   (LEVELS - 2 - d),
            .MODE  (SWEEP_DOWN)
        ) row_i (
            .din  (link[LEVELS + d]),
            .dout (link[LEVELS + d + 1])
        );
    end

    assign prefix = link[NSTAGE];
endmodule

// File: rtl/bk_sum_out.sv
module bk_sum_out
    import bk_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] prop,
    input  gp_t  [WIDTH-1:0] prefix,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH-1:0] carry_in_bit;

    for (genvar i = 0; i < WIDTH; i++) begin : g_carry
        if (i == 0) begin : g_low
            assign carry_in_bit[i] = cin;
        end else begin : g_high
            assign carry_in_bit[i] = prefix[i - 1].g;
        end
    end

    assign sum  = prop ^ carry_in_bit;
    assign cout = prefix[WIDTH - 1].g;
endmodule

// File: rtl/bk_adder.sv
module bk_adder
    import bk_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH-1:0] prop;
    gp_t  [WIDTH-1:0] leaf;
    gp_t  [WIDTH-1:0] prefix;

    bk_gp_gen #(.WIDTH(WIDTH)) gen_i (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .prop (prop),
        .leaf (leaf)
    );

    bk_prefix_net #(.WIDTH(WIDTH)) net_i (
        .leaf   (leaf),
        .prefix (prefix)
    );

    bk_sum_out #(.WIDTH(WIDTH)) out_i (
        .prop   (prop),
        .prefix (prefix),
        .cin    (cin),
        .sum    (sum),
        .cout   (cout)
    );
endmodule

// File: rtl/bk_adder_chk.sv
module bk_adder_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);
    logic [WIDTH:0] total;
    assign total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    always_comb begin
        // R1 and R2: full arithmetic total
        a_r1_total: assert ({cout, sum} == total)
            else $error("R1 total mismatch");
        // R2: carry out implies wrap below both operands
        a_r2_wrap_low: assert (!cout || ((sum <= a) && (sum <= b)))
            else $error("R2 carry without wrap");
        a_r2_no_wrap: assert (cout || ((sum >= a) && (sum >= b)))
            else $error("R2 wrap without carry");
        // R4: all positions propagate
        a_r4_all_prop: assert (((a ^ b) != {WIDTH{1'b1}}) ||
                               ((sum == {WIDTH{~cin}}) && (cout == cin)))
            else $error("R4 full propagate");
        // R5: zero operands
        a_r5_zero_ops: assert ((a != '0) || (b != '0) ||
                               ((sum == {{(WIDTH-1){1'b0}}, cin}) && !cout))
            else $error("R5 zero operands");
        // R7: saturated operands with carry
        a_r7_all_ones: assert ((a != {WIDTH{1'b1}}) || (b != {WIDTH{1'b1}}) || !cin ||
                               ((sum == {WIDTH{1'b1}}) && cout))
            else $error("R7 all ones");
    end
endmodule

bind bk_adder bk_adder_chk #(.WIDTH(WIDTH)) chk_i (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/bk_adder_tb_top.sv
`timescale 1ns/1ps
module bk_adder_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [7:0]  a8, b8, s8;
    logic        c8, co8;
    logic [31:0] a32, b32, s32;
    logic        c32, co32;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    int cycles   = 0;

    bk_adder #(.WIDTH(8)) dut_i (
        .a (a8), .b (b8), .cin (c8), .sum (s8), .cout (co8)
    );

    bk_adder #(.WIDTH(32)) dut_w_i (
        .a (a32), .b (b32), .cin (c32), .sum (s32), .cout (co32)
    );

    function automatic logic [32:0] ref8(input logic [7:0] x, input logic [7:0] y, input logic c);
        logic [8:0] t;
        t = {1'b0, x} + {1'b0, y} + {8'd0, c};
        return {24'd0, t};
    endfunction

    function automatic logic [32:0] ref32(input logic [31:0] x, input logic [31:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {32'd0, c};
    endfunction

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply8(input logic [7:0] x, input logic [7:0] y, input logic c);
        @(negedge clk);
        a8 = x; b8 = y; c8 = c;
        #1;
    endtask

    task automatic apply32(input logic [31:0] x, input logic [31:0] y, input logic c);
        @(negedge clk);
        a32 = x; b32 = y; c32 = c;
        #1;
    endtask

    task automatic run32(input string req, input logic [31:0] x, input logic [31:0] y, input logic c);
        logic [32:0] first;
        apply32(x, y, c);
        first = {co32, s32};
        check(req, first, ref32(x, y, c));
        apply32(y, x, c);
        check("R6 swap32", {co32, s32}, first);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        a8 = '0; b8 = '0; c8 = 1'b0;
        a32 = '0; b32 = '0; c32 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R5: idle state after reset with zero operands
        apply8(8'd0, 8'd0, 1'b0);
        check("R5 reset state 8", {24'd0, co8, s8}, 33'd0);
        apply32(32'd0, 32'd0, 1'b1);
        check("R5 zero ops cin 32", {co32, s32}, 33'd1);

        // R8 with R1 R2 R3: exhaustive 8-bit sweep
        for (int c = 0; c < 2; c++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    apply8(8'(x), 8'(y), 1'(c));
                    if (c == 0)
                        check("R3 no-carry 8", {24'd0, co8, s8}, ref8(8'(x), 8'(y), 1'b0));
                    else
                        check("R1 R2 R8 exhaustive 8", {24'd0, co8, s8}, ref8(8'(x), 8'(y), 1'b1));
                end
            end
        end

        // R4: all-propagate patterns at 32 bits
        run32("R4 prop cin0", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
        run32("R4 prop cin1", 32'hF0F0_0F0F, 32'h0F0F_F0F0, 1'b1);
        apply32(32'h1234_5678, ~32'h1234_5678, 1'b1);
        check("R4 prop sum zero", {co32, s32}, {1'b1, 32'd0});
        // R7: saturated operands
        run32("R7 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        apply8(8'hFF, 8'hFF, 1'b1);
        check("R7 all ones 8", {24'd0, co8, s8}, {24'd0, 9'h1FF});
        // R2: single carry travelling the whole chain
        run32("R2 long chain", 32'hFFFF_FFFF, 32'd0, 1'b1);
        run32("R2 top carry", 32'h8000_0000, 32'h8000_0000, 1'b0);
        // R1 R8: each single-bit carry position
        for (int k = 0; k < 32; k++) begin
            run32("R1 carry position", (32'd1 << k) - 32'd1, 32'd1, 1'b0);
        end

        // R1 R3 R6 R8: random 32-bit vectors from a fixed seed
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] x, y;
            logic        c;
            x = $urandom;
            y = $urandom;
            c = 1'($urandom);
            if (c) run32("R1 random 32", x, y, 1'b1);
            else   run32("R3 random 32", x, y, 1'b0);
        end

        finish_run();
    end

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            finish_run();
        end
    end
endmodule